// File: doc/BRIEF.md
# Power-Up Reset Release Sequencer

This block decides when a device may leave reset after power is applied. It watches a power-on pulse and an active-low external clear pin. A counter runs on a slow, low-frequency clock and is enabled by a configuration bit. When the counter is enabled, it keeps the internal reset asserted for a fixed number of slow-clock periods after the power-on pulse ends. The default is a 13-bit counter with a terminal count of 2047, which gives a delay in the tens of milliseconds on a 32 µs clock.

The delay counter starts when the power-on pulse ends, whatever the state of the clear pin. If the clear pin is still low when the delay has passed, raising the pin releases reset after the pin's synchronizer latency only, with no new delay. A fresh power-on pulse clears the counter and starts the whole interval again. A clear-pin assertion does not touch the counter. When the enable bit is clear, the delay is skipped.

Top module: `pwrup_seq`

## Requirements
- R1: `rst_int` is high whenever `por_pulse` is high, from the same instant and without waiting for a clock edge.
- R2: With `tmr_en` = 1, `tmr_busy` stays high for exactly TERM_CNT rising edges of `clk_lf` after `por_pulse` falls, then goes low.
- R3: `rst_int` is high on every cycle in which `tmr_busy` is high.
- R4: With `tmr_en` = 0, `tmr_busy` never asserts. `rst_int` falls two `clk_lf` edges after `por_pulse` falls, provided `clr_n` is high.
- R5: `clr_n` passes through a two-stage synchronizer into the `clk_lf` domain. `rst_int` rises on the second edge after `clr_n` is sampled low, and falls on the second edge after `clr_n` is sampled high, if nothing else holds reset.
- R6: The delay counter ignores `clr_n`. Holding `clr_n` low, or pulsing it low, during the delay does not move the expiry edge. Raising `clr_n` after expiry releases reset after only the synchronizer latency.
- R7: A new `por_pulse` during or after the delay clears the counter at once, so `tmr_busy` is high while the pulse lasts and for the full TERM_CNT edges after it ends.
- R8: Once the terminal count is reached, the counter saturates and `tmr_busy` stays low until the next `por_pulse`.
- R9: While `por_pulse` is high, `tmr_busy` equals `tmr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lf | input | 1 | Slow low-frequency clock driving the delay counter |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous |
| clr_n | input | 1 | External clear pin, active low, asynchronous |
| tmr_en | input | 1 | Configuration bit that enables the delay stage |
| rst_int | output | 1 | Internal reset, active high |
| tmr_busy | output | 1 | High while the delay counter is running |

## Verification
The bench measures the delay to the exact edge. A counter that is off by one would drop `tmr_busy` one edge early or late. The bench holds the clear pin low across expiry. A design that started the counter from the pin would then still show busy, or would wait a whole new interval after the pin rises. A short clear pulse during the delay checks that the pin does not restart the counter. A second power-on pulse in the middle of the delay checks that the counter does restart, and a design that kept counting would release reset early. A long run past expiry catches a counter that wraps instead of saturating, which would raise busy again.

// File: rtl/pwrup_seq.sv
module pwrup_seq #(
  parameter int CNT_W       = 13,
  parameter int TERM_CNT    = 2047,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_lf,
  input  logic por_pulse,
  input  logic clr_n,
  input  logic tmr_en,
  output logic rst_int,
  output logic tmr_busy
);

  localparam logic [CNT_W-1:0] TERM = CNT_W'(TERM_CNT);

  logic [SYNC_STAGES-1:0] clr_sync;
  logic [CNT_W-1:0]       cnt;
  logic                   at_term;
  logic                   clr_ok;

  always_ff @(posedge clk_lf or posedge por_pulse)
    if (por_pulse) clr_sync <= '0;
    else           clr_sync <= {clr_sync[SYNC_STAGES-2:0], clr_n};

  always_ff @(posedge clk_lf or posedge por_pulse)
    if (por_pulse)                cnt <= '0;
    else if (tmr_en && !at_term)  cnt <= cnt + 1'b1;

  assign at_term  = (cnt == TERM);
  assign clr_ok   = clr_sync[SYNC_STAGES-1];
  assign tmr_busy = tmr_en & ~at_term;
  assign rst_int  = por_pulse | tmr_busy | ~clr_ok;

endmodule

module pwrup_seq_chk (
  input logic clk_lf,
  input logic por_pulse,
  input logic clr_n,
  input logic tmr_en,
  input logic rst_int,
  input logic tmr_busy
);

  a_r1_por_holds_reset: assert property (@(posedge clk_lf)
    por_pulse |-> rst_int);

  a_r3_busy_holds_reset: assert property (@(posedge clk_lf) disable iff (por_pulse)
    tmr_busy |-> rst_int);

  a_r4_bypass_never_busy: assert property (@(posedge clk_lf) disable iff (por_pulse)
    !tmr_en |-> !tmr_busy);

  a_r5_pin_low_resets: assert property (@(posedge clk_lf) disable iff (por_pulse)
    !clr_n |-> ##2 rst_int);

  a_r8_saturate: assert property (@(posedge clk_lf) disable iff (por_pulse)
    (tmr_en && !tmr_busy) |=> !tmr_busy);

  a_r9_por_busy_level: assert property (@(posedge clk_lf)
    por_pulse |-> (tmr_busy == tmr_en));

endmodule

bind pwrup_seq pwrup_seq_chk i_pwrup_seq_chk (.*);

// File: tb/test_pwrup_seq.sv
module test_pwrup_seq;
  localparam int TERM = 8;

  logic clk_lf = 1'b0;
  logic por_pulse = 1'b1;
  logic clr_n = 1'b1;
  logic tmr_en = 1'b1;
  logic rst_int, tmr_busy;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_lf = ~clk_lf;

  pwrup_seq #(.CNT_W(13), .TERM_CNT(TERM), .SYNC_STAGES(2)) i_pwrup_seq (
    .clk_lf(clk_lf), .por_pulse(por_pulse), .clr_n(clr_n), .tmr_en(tmr_en),
    .rst_int(rst_int), .tmr_busy(tmr_busy));

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_lf);
  endtask

  task automatic start_por(input logic en);
    por_pulse = 1'b1; tmr_en = en;
    cyc(2);
    por_pulse = 1'b0;
  endtask

  task automatic t_reset_state();
    chk(rst_int, 1'b1, "R1 reset during power-on");
    chk(tmr_busy, 1'b1, "R9 busy follows enable during power-on");
  endtask

  task automatic t_normal_delay();
    por_pulse = 1'b0;
    cyc(TERM - 1);
    chk(tmr_busy, 1'b1, "R2 busy one edge before expiry");
    chk(rst_int, 1'b1, "R3 reset held while busy");
    cyc(1);
    chk(tmr_busy, 1'b0, "R2 busy drops at terminal count");
    chk(rst_int, 1'b0, "R2 reset released at expiry");
  endtask

  task automatic t_saturate();
    cyc(3 * TERM);
    chk(tmr_busy, 1'b0, "R8 busy stays low after saturation");
    chk(rst_int, 1'b0, "R8 reset stays released");
  endtask

  task automatic t_pin_sync();
    clr_n = 1'b0;
    cyc(1);
    chk(rst_int, 1'b0, "R5 one edge of synchronizer latency");
    cyc(1);
    chk(rst_int, 1'b1, "R5 reset after two edges");
    clr_n = 1'b1;
    cyc(1);
    chk(rst_int, 1'b1, "R5 release still in synchronizer");
    cyc(1);
    chk(rst_int, 1'b0, "R5 release after two edges");
    chk(tmr_busy, 1'b0, "R6 pin did not restart counter");
  endtask

  task automatic t_por_restart();
    start_por(1'b1);
    cyc(3);
    por_pulse = 1'b1;
    #1;
    chk(rst_int, 1'b1, "R1 immediate reset on new power-on");
    chk(tmr_busy, 1'b1, "R7 counter cleared by new power-on");
    cyc(1);
    por_pulse = 1'b0;
    cyc(TERM - 1);
    chk(tmr_busy, 1'b1, "R7 full interval after restart");
    cyc(1);
    chk(tmr_busy, 1'b0, "R7 expiry after full interval");
  endtask

  task automatic t_expire_pin_low();
    clr_n = 1'b0;
    start_por(1'b1);
    cyc(TERM);
    chk(tmr_busy, 1'b0, "R6 timer expires while pin low");
    chk(rst_int, 1'b1, "R6 reset held by pin");
    clr_n = 1'b1;
    cyc(2);
    chk(rst_int, 1'b0, "R6 release without new delay");
    chk(tmr_busy, 1'b0, "R6 no new delay started");
  endtask

  task automatic t_pin_pulse_in_delay();
    start_por(1'b1);
    cyc(2);
    clr_n = 1'b0;
    cyc(2);
    clr_n = 1'b1;
    cyc(TERM - 5);
    chk(tmr_busy, 1'b1, "R6 busy before unchanged expiry");
    cyc(1);
    chk(tmr_busy, 1'b0, "R6 expiry edge unmoved by pin pulse");
    chk(rst_int, 1'b0, "R6 reset released");
  endtask

  task automatic t_bypass();
    por_pulse = 1'b1; tmr_en = 1'b0;
    cyc(2);
    chk(tmr_busy, 1'b0, "R9 busy low when disabled in power-on");
    por_pulse = 1'b0;
    cyc(1);
    chk(rst_int, 1'b1, "R4 synchronizer still filling");
    cyc(1);
    chk(rst_int, 1'b0, "R4 bypass releases after two edges");
    chk(tmr_busy, 1'b0, "R4 busy never asserts");
    tmr_en = 1'b1;
  endtask

  initial begin
    cyc(2);
    t_reset_state();
    t_normal_delay();
    t_saturate();
    t_pin_sync();
    t_por_restart();
    t_expire_pin_low();
    t_pin_pulse_in_delay();
    t_bypass();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule